// File: doc/BRIEF.md
# Bus-Matching Width Converter

This block sits between a 36-bit internal word stream and an external data port whose usable width can be 36, 18 or 9 bits. In the inbound direction it collects one, two or four narrow port transfers and delivers them as a single 36-bit word. In the outbound direction it takes one 36-bit word and hands it out as one, two or four narrow transfers. Both directions use a valid/ready handshake on each side, and they run independently of each other.

The port size and the sub-word order are static settings. They are captured while reset is held and then stay fixed until the next reset. In the 18-bit and 9-bit sizes the sub-word order is selectable. Big-endian order moves the most significant piece first. Little-endian order moves the least significant piece first. Narrow transfers always use the low bits of the 36-bit port buses.

Top module: `bus_width_matcher`

## Requirements
- R1: `cfgSize` encodes the port size as 0 = 36-bit, 1 = 18-bit, 2 = 9-bit and 3 = 36-bit. `cfgLittle` = 1 selects little-endian order. Both are sampled only while `rstN` is low, and changing them after reset has no effect until the next reset.
- R2: In 36-bit mode every port transfer on `portIn*` becomes one wide word, and every wide word on `wideIn*` becomes one port transfer, each carrying all 36 bits unchanged.
- R3: In 18-bit mode two transfers on `portInData[17:0]` form a wide word. With big-endian order the first transfer fills bits [35:18]. With little-endian order the first transfer fills bits [17:0].
- R4: In 9-bit mode four transfers on `portInData[8:0]` form a wide word. With big-endian order the transfers fill bits [35:27], [26:18], [17:9] and [8:0] in that order. Little-endian order fills the same slices in the reverse order.
- R5: `wideOutValid` stays low until the last sub-word of a word has been accepted. A partially assembled word is never presented.
- R6: In 18-bit mode a wide word is sent as two transfers on `portOutData[17:0]`, in the order given by R3, with `portOutData[35:18]` = 0.
- R7: In 9-bit mode a wide word is sent as four transfers on `portOutData[8:0]`, in the order given by R4, with `portOutData[35:9]` = 0.
- R8: While a valid output is not accepted, its valid stays high and its data stays unchanged. No data is lost or repeated across stalls.
- R9: After reset `wideOutValid` and `portOutValid` are 0 and both input readies are 1. A partial word that was in progress before the reset is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; the configuration is captured while it is low |
| cfgSize | input | 2 | Port size select (0/3 = 36, 1 = 18, 2 = 9 bits) |
| cfgLittle | input | 1 | 1 = least significant sub-word first |
| portInData | input | 36 | Narrow inbound data, using the low bits in narrow modes |
| portInValid | input | 1 | Inbound sub-word valid |
| portInReady | output | 1 | Inbound sub-word accepted |
| wideOutData | output | 36 | Assembled wide word |
| wideOutValid | output | 1 | Assembled word valid |
| wideOutReady | input | 1 | Downstream takes the wide word |
| wideInData | input | 36 | Wide word to split |
| wideInValid | input | 1 | Wide word valid |
| wideInReady | output | 1 | Wide word accepted |
| portOutData | output | 36 | Narrow outbound data, with unused upper bits zero |
| portOutValid | output | 1 | Outbound sub-word valid |
| portOutReady | input | 1 | Outbound sub-word taken |

## Verification
The bench runs every size and both orders with words whose sub-words are all different from each other. A swapped lane index or a reversed order therefore shows up as a wrong wide word or a wrong sub-word sequence. It checks that the wide side stays silent between sub-words, which catches a design that pushes too early or that counts one piece too few. It holds both output sides stalled and checks that the data does not change, which catches a counter that keeps advancing under backpressure. It also changes the configuration after reset and resets in the middle of a word, which catch a design that follows the live settings or keeps a stale lane count.

// File: rtl/bm_pkg.sv
package bm_pkg;

  typedef enum logic [1:0] {
    SZ_LONG = 2'd0,
    SZ_HALF = 2'd1,
    SZ_BYTE = 2'd2,
    SZ_RSVD = 2'd3
  } portSize_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic      wrTake;   // a sub-word is accepted this cycle
    logic [1:0] wrLane;  // lane that sub-word lands in
    portSize_e size;     // effective size (never SZ_RSVD)
    logic      rdLoad;   // a wide word is loaded this cycle
    logic [1:0] rdLane;  // lane currently presented
  } bmStrobe_t;

endpackage

// File: rtl/bm_ctrl.sv
module bm_ctrl
  import bm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] cfgSize,
  input  logic       cfgLittle,
  input  logic       portInValid,
  output logic       portInReady,
  output logic       wideOutValid,
  input  logic       wideOutReady,
  input  logic       wideInValid,
  output logic       wideInReady,
  output logic       portOutValid,
  input  logic       portOutReady,
  output bmStrobe_t  strb
);

  portSize_e sizeQ;
  portSize_e sizeEff;
  logic      littleQ;
  logic [1:0] lastIdx;
  logic [1:0] wrCnt, rdCnt;
  logic      wrFull, rdFull;
  logic      wrTake, wrLast, wrPop;
  logic      rdAdv, rdLast, rdLoad;

  always_comb begin
    unique case (sizeQ)
      SZ_HALF: begin sizeEff = SZ_HALF; lastIdx = 2'd1; end
      SZ_BYTE: begin sizeEff = SZ_BYTE; lastIdx = 2'd3; end
      default: begin sizeEff = SZ_LONG; lastIdx = 2'd0; end
    endcase
  end

  // Write path: narrow -> wide
  assign wideOutValid = wrFull;
  assign portInReady  = !wrFull || wideOutReady;
  assign wrTake       = portInValid && portInReady;
  assign wrLast       = (wrCnt == lastIdx);
  assign wrPop        = wrFull && wideOutReady;

  // Read path: wide -> narrow
  assign portOutValid = rdFull;
  assign rdAdv        = rdFull && portOutReady;
  assign rdLast       = (rdCnt == lastIdx);
  assign wideInReady  = !rdFull || (portOutReady && rdLast);
  assign rdLoad       = wideInValid && wideInReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sizeQ   <= portSize_e'(cfgSize);
      littleQ <= cfgLittle;
      wrCnt   <= '0;
      wrFull  <= 1'b0;
      rdCnt   <= '0;
      rdFull  <= 1'b0;
    end else begin
      if (wrTake) wrCnt <= wrLast ? 2'd0 : wrCnt + 2'd1;
      if (wrTake && wrLast) wrFull <= 1'b1;
      else if (wrPop)       wrFull <= 1'b0;

      if (rdAdv) rdCnt <= rdLast ? 2'd0 : rdCnt + 2'd1;
      if (rdLoad)               rdFull <= 1'b1;
      else if (rdAdv && rdLast) rdFull <= 1'b0;
    end
  end

  always_comb begin
    strb.wrTake = wrTake;
    strb.wrLane = littleQ ? wrCnt : lastIdx - wrCnt;
    strb.size   = sizeEff;
    strb.rdLoad = rdLoad;
    strb.rdLane = littleQ ? rdCnt : lastIdx - rdCnt;
  end

  // R5: the wide side only turns valid on the cycle after a final sub-word
  p_no_partial_push_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wideOutValid) |-> $past(portInValid && portInReady));

  // R5: sub-word counter never passes the last lane of the active size
  p_wr_cnt_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrCnt <= lastIdx);

  // R8: an outbound sub-word that is not taken stays offered
  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    portOutValid && !portOutReady |=> portOutValid);

  // R1: captured settings do not move outside reset
  p_cfg_locked_r1: assert property (@(posedge clk) disable iff (!rstN)
    rstN && $past(rstN) |-> $stable(sizeQ) && $stable(littleQ));

endmodule

// File: rtl/bm_datapath.sv
module bm_datapath
  import bm_pkg::*;
#(
  parameter int WordW = 36
) (
  input  logic             clk,
  input  bmStrobe_t        strb,
  input  logic [WordW-1:0] portInData,
  output logic [WordW-1:0] wideOutData,
  input  logic [WordW-1:0] wideInData,
  output logic [WordW-1:0] portOutData
);

  localparam int Lanes = 4;
  localparam int ByteW = WordW / Lanes;
  localparam int HalfW = WordW / 2;

  logic [ByteW-1:0] asmLane  [Lanes];
  logic [ByteW-1:0] holdLane [Lanes];
  logic [HalfW-1:0] holdHalf [2];
  logic [WordW-1:0] holdQ;

  always_ff @(posedge clk) begin
    if (strb.rdLoad) holdQ <= wideInData;
  end

  for (genvar g = 0; g < Lanes; g++) begin : g_lane
    logic             laneWe;
    logic [ByteW-1:0] laneSrc;

    always_comb begin
      unique case (strb.size)
        SZ_HALF: begin
          laneWe  = strb.wrTake && (strb.wrLane[0] == 1'(g / 2));
          laneSrc = portInData[(g % 2)*ByteW +: ByteW];
        end
        SZ_BYTE: begin
          laneWe  = strb.wrTake && (strb.wrLane == 2'(g));
          laneSrc = portInData[ByteW-1:0];
        end
        default: begin
          laneWe  = strb.wrTake;
          laneSrc = portInData[g*ByteW +: ByteW];
        end
      endcase
    end

    always_ff @(posedge clk) begin
      if (laneWe) asmLane[g] <= laneSrc;
    end

    assign wideOutData[g*ByteW +: ByteW] = asmLane[g];
    assign holdLane[g] = holdQ[g*ByteW +: ByteW];
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign holdHalf[h] = holdQ[h*HalfW +: HalfW];
  end

  always_comb begin
    unique case (strb.size)
      SZ_HALF: portOutData = {{(WordW-HalfW){1'b0}}, holdHalf[strb.rdLane[0]]};
      SZ_BYTE: portOutData = {{(WordW-ByteW){1'b0}}, holdLane[strb.rdLane]};
      default: portOutData = holdQ;
    endcase
  end

endmodule

// File: rtl/bus_width_matcher.sv
module bus_width_matcher
  import bm_pkg::*;
#(
  parameter int WordW = 36
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       cfgSize,
  input  logic             cfgLittle,
  input  logic [WordW-1:0] portInData,
  input  logic             portInValid,
  output logic             portInReady,
  output logic [WordW-1:0] wideOutData,
  output logic             wideOutValid,
  input  logic             wideOutReady,
  input  logic [WordW-1:0] wideInData,
  input  logic             wideInValid,
  output logic             wideInReady,
  output logic [WordW-1:0] portOutData,
  output logic             portOutValid,
  input  logic             portOutReady
);

  localparam int ByteW = WordW / 4;
  localparam int HalfW = WordW / 2;

  bmStrobe_t strb;

  bm_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .cfgSize      (cfgSize),
    .cfgLittle    (cfgLittle),
    .portInValid  (portInValid),
    .portInReady  (portInReady),
    .wideOutValid (wideOutValid),
    .wideOutReady (wideOutReady),
    .wideInValid  (wideInValid),
    .wideInReady  (wideInReady),
    .portOutValid (portOutValid),
    .portOutReady (portOutReady),
    .strb         (strb)
  );

  bm_datapath #(.WordW(WordW)) dp_i (
    .clk         (clk),
    .strb        (strb),
    .portInData  (portInData),
    .wideOutData (wideOutData),
    .wideInData  (wideInData),
    .portOutData (portOutData)
  );

  // R8: an assembled word waits unchanged for the downstream side
  p_wide_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    wideOutValid && !wideOutReady |=> wideOutValid && $stable(wideOutData));

  // R8: a stalled outbound sub-word keeps its value
  p_port_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    portOutValid && !portOutReady |=> $stable(portOutData));

  // R7: unused upper port bits are zero in byte mode
  p_byte_upper_r7: assert property (@(posedge clk) disable iff (!rstN)
    portOutValid && strb.size == SZ_BYTE |-> portOutData[WordW-1:ByteW] == '0);

  // R6: unused upper port bits are zero in half mode
  p_half_upper_r6: assert property (@(posedge clk) disable iff (!rstN)
    portOutValid && strb.size == SZ_HALF |-> portOutData[WordW-1:HalfW] == '0);

endmodule

// File: tb/bus_width_matcher_tb_top.sv
module bus_width_matcher_tb_top;

  localparam int CLK_P = 10;
  localparam int NVEC  = 8;

  // {size[1:0], little, word[35:0]}
  localparam logic [38:0] VECS [NVEC] = '{
    {2'd0, 1'b0, 36'h123456789},
    {2'd1, 1'b0, 36'hABCDE1234},
    {2'd1, 1'b1, 36'h13579BDF0},
    {2'd2, 1'b0, 36'h0FEDCBA98},
    {2'd2, 1'b1, 36'hA5A5C3C3E},
    {2'd3, 1'b0, 36'h800000001},
    {2'd2, 1'b1, 36'h1FF000E01},
    {2'd1, 1'b0, 36'h9ABCDEF01}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  cfgSize = 2'd0;
  logic        cfgLittle = 1'b0;
  logic [35:0] portInData = '0;
  logic        portInValid = 1'b0;
  logic        portInReady;
  logic [35:0] wideOutData;
  logic        wideOutValid;
  logic        wideOutReady = 1'b0;
  logic [35:0] wideInData = '0;
  logic        wideInValid = 1'b0;
  logic        wideInReady;
  logic [35:0] portOutData;
  logic        portOutValid;
  logic        portOutReady = 1'b0;

  int testCnt = 0;
  int failCnt = 0;

  always #(CLK_P/2) clk = ~clk;

  bus_width_matcher dut_i (
    .clk(clk), .rstN(rstN), .cfgSize(cfgSize), .cfgLittle(cfgLittle),
    .portInData(portInData), .portInValid(portInValid), .portInReady(portInReady),
    .wideOutData(wideOutData), .wideOutValid(wideOutValid), .wideOutReady(wideOutReady),
    .wideInData(wideInData), .wideInValid(wideInValid), .wideInReady(wideInReady),
    .portOutData(portOutData), .portOutValid(portOutValid), .portOutReady(portOutReady)
  );

  task automatic chk(input logic [35:0] act, input logic [35:0] exp, input string tag);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int nSub(input logic [1:0] sz);
    return (sz == 2'd1) ? 2 : (sz == 2'd2) ? 4 : 1;
  endfunction

  function automatic logic [35:0] subOf(input logic [35:0] w, input logic [1:0] sz,
                                        input logic lit, input int k);
    int n = nSub(sz);
    int wd = 36 / n;
    int lane = lit ? k : n - 1 - k;
    logic [35:0] mask = (n == 1) ? {36{1'b1}} : ((36'd1 << wd) - 36'd1);
    return (w >> (lane * wd)) & mask;
  endfunction

  task automatic doReset(input logic [1:0] sz, input logic lit);
    @(negedge clk);
    cfgSize = sz; cfgLittle = lit; rstN = 1'b0;
    portInValid = 1'b0; wideInValid = 1'b0; wideOutReady = 1'b0; portOutReady = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk({35'd0, wideOutValid}, 36'd0, "R9 wideOutValid after reset");
    chk({35'd0, portOutValid}, 36'd0, "R9 portOutValid after reset");
    chk({35'd0, portInReady},  36'd1, "R9 portInReady after reset");
    chk({35'd0, wideInReady},  36'd1, "R9 wideInReady after reset");
  endtask

  // model size/order used to form sub-words; tag names the requirement
  task automatic writeWord(input logic [35:0] w, input logic [1:0] sz,
                           input logic lit, input string tag);
    int n = nSub(sz);
    for (int k = 0; k < n; k++) begin
      portInData = subOf(w, sz, lit, k);
      portInValid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      if (k < n - 1) chk({35'd0, wideOutValid}, 36'd0, "R5 no partial push");
    end
    portInValid = 1'b0;
    chk({35'd0, wideOutValid}, 36'd1, {tag, " wide valid"});
    chk(wideOutData, w, {tag, " wide data"});
    @(negedge clk);
    chk({35'd0, wideOutValid}, 36'd1, "R8 wide valid held");
    chk(wideOutData, w, "R8 wide data held");
    wideOutReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wideOutReady = 1'b0;
    chk({35'd0, wideOutValid}, 36'd0, {tag, " wide drained"});
  endtask

  task automatic readWord(input logic [35:0] w, input logic [1:0] sz,
                          input logic lit, input string tag);
    int n = nSub(sz);
    wideInData = w; wideInValid = 1'b1; portOutReady = 1'b0;
    @(posedge clk);
    @(negedge clk);
    wideInValid = 1'b0;
    for (int k = 0; k < n; k++) begin
      chk({35'd0, portOutValid}, 36'd1, {tag, " port valid"});
      chk(portOutData, subOf(w, sz, lit, k), {tag, " port data"});
      if (k == 0) begin
        @(posedge clk);
        @(negedge clk);
        chk(portOutData, subOf(w, sz, lit, k), "R8 port data held");
      end
      portOutReady = 1'b1;
      @(posedge clk);
      @(negedge clk);
      portOutReady = 1'b0;
    end
    chk({35'd0, portOutValid}, 36'd0, {tag, " port drained"});
  endtask

  initial begin
    #(CLK_P * 50000);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    for (int i = 0; i < NVEC; i++) begin
      logic [1:0]  sz  = VECS[i][38:37];
      logic        lit = VECS[i][36];
      logic [35:0] w   = VECS[i][35:0];
      string wt = (sz == 2'd1) ? "R3" : (sz == 2'd2) ? "R4" : "R2";
      string rt = (sz == 2'd1) ? "R6" : (sz == 2'd2) ? "R7" : "R2";
      doReset(sz, lit);
      @(negedge clk);
      writeWord(w, sz, lit, wt);
      readWord(w, sz, lit, rt);
    end

    // R1: settings changed after reset are ignored
    doReset(2'd2, 1'b0);
    cfgSize = 2'd0; cfgLittle = 1'b1;
    @(negedge clk);
    writeWord(36'h2468ACE13, 2'd2, 1'b0, "R1 write");
    readWord(36'h2468ACE13, 2'd2, 1'b0, "R1 read");

    // R9: partial word discarded by reset
    doReset(2'd2, 1'b0);
    @(negedge clk);
    portInData = 36'h1AB; portInValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    portInValid = 1'b0;
    doReset(2'd2, 1'b0);
    @(negedge clk);
    writeWord(36'h0C0FFEE55, 2'd2, 1'b0, "R9 after partial");

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule